// File: doc/BRIEF.md
# Split-Array Address Translation Buffer with Region Registers

This block turns 64-bit virtual addresses into physical addresses. The three highest address bits pick one of eight region registers. Each region register holds a region identifier, a preferred page size and a flag that allows a page-table walk. The region identifier is combined with the page number and looked up in two fully associative arrays. The pinned array is loaded into explicit slots by software and hardware never evicts anything from it. The cache array takes inserted entries itself and evicts entries in rotation once it is full.

Each entry carries a region identifier, a page number, a per-entry page size, a physical page number, a rights code, a privilege level and a protection key. A lookup returns, one cycle later, a hit flag, the physical address, the array that supplied the entry, an access fault, a key fault and a machine-check flag. On a miss it returns the walk-enable bit of the selected region, so that a walker outside this block can decide whether to fill the entry. A purge command clears cache entries that overlap a given address range.

Top module: `tlb_split`

## Requirements
- R1: A lookup or insert uses the region register selected by `va[63:61]`. An entry records the region identifier current at insert time and matches only when that identifier equals the identifier of the looked-up region. A region register write takes effect for the following command.
- R2: The legal page sizes, written as log2 of the byte count, are 12, 13, 14, 16, 18, 20, 22, 24, 26, 28 and 32. An `ins_ps` of 0 means that the selected region's preferred size is used. An insert whose effective size is not legal is dropped.
- R3: An entry of size `ps` matches when `va[60:ps]` equals its page bits. The result address takes bits `[ps-1:0]` from the virtual address unchanged and bits `[49:ps]` from `{ppn,12'b0}`.
- R4: The pinned array is written only into the slot that `ins_slot` names, when `ins_tr`=1. Cache inserts and purges never clear a pinned entry.
- R5: A cache insert (`ins_tr`=0) goes to the lowest invalid slot. When no slot is invalid, it overwrites the slot under a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such overwrite only.
- R6: When both arrays hit, the pinned entry supplies the result and `res_from_tr`=1. A result from the cache gives `res_from_tr`=0.
- R7: More than one hit inside the same array sets `res_mchk`=1. The lowest hitting slot still supplies the result.
- R8: `res_key_fault`=1 on a hit when no valid protection key register holds the entry's key.
- R9: Access codes on `lk_acc` are 0 read, 1 write, 2 execute and 3 reserved; code 3 always faults. Rights codes give these permissions:
  - 0: read.
  - 1: read and execute.
  - 2: read and write.
  - 3: read, write and execute.
  - 4: read, plus write when `lk_cpl`=0.
  - 5: read and execute, plus write when `lk_cpl`=0.
  - 6 and 7: nothing.

  `res_acc_fault`=1 when `lk_cpl` is greater than the entry's privilege level or when the rights code does not grant the access.
- R10: On a miss, `res_hit`=0, `res_pa`=0 and both fault flags are 0. `res_walk_en` equals the walk bit of the selected region. On a hit, `res_walk_en`=0.
- R11: A purge clears every valid cache entry whose region identifier equals that of the region selected by `purge_va[63:61]` and whose page overlaps the aligned range of size `purge_ps` that contains `purge_va`.
- R12: The result appears with `res_valid`=1 on the cycle after `lk_valid`=1, and `res_valid`=0 otherwise. Reset clears all entries, region registers, key registers and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_we | input | 1 | Region register write strobe |
| rr_idx | input | 3 | Region register index |
| rr_rid | input | 8 | Region identifier to store |
| rr_ps | input | 6 | Preferred page size (log2) to store |
| rr_walk | input | 1 | Walk-enable bit to store |
| pk_we | input | 1 | Protection key register write strobe |
| pk_idx | input | 4 | Protection key register index |
| pk_valid | input | 1 | Valid bit to store |
| pk_key | input | 8 | Key value to store |
| ins_en | input | 1 | Insert command |
| ins_tr | input | 1 | 1: pinned array, 0: cache array |
| ins_slot | input | 2 | Pinned slot number |
| ins_va | input | 52 | Virtual address bits [63:12] of the new entry |
| ins_ps | input | 6 | Page size (log2), 0 for the region default |
| ins_ppn | input | 38 | Physical page number (physical bits [49:12]) |
| ins_ar | input | 3 | Rights code |
| ins_pl | input | 2 | Privilege level |
| ins_key | input | 8 | Protection key |
| purge_en | input | 1 | Purge command |
| purge_va | input | 52 | Purge address bits [63:12] |
| purge_ps | input | 6 | Purge range size (log2) |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_acc | input | 2 | Access kind |
| lk_cpl | input | 2 | Current privilege level |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Translation found |
| res_from_tr | output | 1 | Result came from the pinned array |
| res_pa | output | 50 | Physical address |
| res_acc_fault | output | 1 | Rights or privilege fault |
| res_key_fault | output | 1 | Protection key miss |
| res_mchk | output | 1 | Multiple hits inside one array |
| res_walk_en | output | 1 | Miss with walking allowed in the region |

## Verification
The fill-count and purge-count properties on the cache assume that an insert and a purge never arrive in the same cycle. The bench issues each command in a cycle of its own and leaves idle cycles between commands. The machine-check property assumes that results are only read together with a hit. Duplicate entries are created only on purpose, to reach the multi-hit case. All page sizes, rights codes, privilege levels and access kinds are swept. Region identifiers and page numbers are chosen so that the expected hit or miss follows from the region and size arithmetic alone.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W    = 64;
    localparam int PA_W    = 50;
    localparam int PG_MIN  = 12;
    localparam int REG_W   = 3;
    localparam int N_REG   = 1 << REG_W;
    localparam int VPN_W   = VA_W - REG_W - PG_MIN;
    localparam int PPN_W   = PA_W - PG_MIN;
    localparam int RID_W   = 8;
    localparam int KEY_W   = 8;
    localparam int PS_W    = 6;
    localparam int AR_W    = 3;
    localparam int PL_W    = 2;

    typedef struct packed {
        logic              valid;
        logic [RID_W-1:0]  rid;
        logic [VPN_W-1:0]  vpn;
        logic [PS_W-1:0]   ps;
        logic [PPN_W-1:0]  ppn;
        logic [AR_W-1:0]   ar;
        logic [PL_W-1:0]   pl;
        logic [KEY_W-1:0]  key;
    } tlb_entry_t;

    typedef struct packed {
        logic [RID_W-1:0]  rid;
        logic [PS_W-1:0]   ps;
        logic              walk;
    } region_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    function automatic logic ps_supported(input logic [PS_W-1:0] ps);
        case (ps)
            6'd12, 6'd13, 6'd14, 6'd16, 6'd18, 6'd20,
            6'd22, 6'd24, 6'd26, 6'd28, 6'd32: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    // Page-number bits that take part in a compare for a page of size ps.
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [PS_W-1:0] ps);
        logic [PS_W-1:0] sh;
        if (ps <= PS_W'(PG_MIN)) return '1;
        sh = ps - PS_W'(PG_MIN);
        return {VPN_W{1'b1}} << sh;
    endfunction

    function automatic logic [PA_W-1:0] offset_mask(input logic [PS_W-1:0] ps);
        return (PA_W'(1) << ps) - PA_W'(1);
    endfunction

    function automatic logic entry_matches(input tlb_entry_t e,
                                           input logic [RID_W-1:0] rid,
                                           input logic [VPN_W-1:0] vpn);
        return e.valid && (e.rid == rid) && (((e.vpn ^ vpn) & vpn_mask(e.ps)) == '0);
    endfunction

    function automatic logic range_overlap(input tlb_entry_t e,
                                           input logic [RID_W-1:0] rid,
                                           input logic [VPN_W-1:0] vpn,
                                           input logic [PS_W-1:0] ps);
        logic [PS_W-1:0] big;
        big = (e.ps > ps) ? e.ps : ps;
        return e.valid && (e.rid == rid) && (((e.vpn ^ vpn) & vpn_mask(big)) == '0);
    endfunction

    // {exec, write, read}
    function automatic logic [2:0] rights_of(input logic [AR_W-1:0] ar,
                                             input logic [PL_W-1:0] cpl);
        logic top;
        top = (cpl == '0);
        case (ar)
            3'd0:    return 3'b001;
            3'd1:    return 3'b101;
            3'd2:    return 3'b011;
            3'd3:    return 3'b111;
            3'd4:    return {1'b0, top, 1'b1};
            3'd5:    return {1'b1, top, 1'b1};
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/tlb_region_file.sv
module tlb_region_file
    import tlb_pkg::*;
#(
    parameter int N_PKR = 16,
    localparam int PK_IDX_W = (N_PKR > 1) ? $clog2(N_PKR) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rr_we,
    input  logic [REG_W-1:0]    rr_idx,
    input  region_t             rr_data,
    input  logic                pk_we,
    input  logic [PK_IDX_W-1:0] pk_idx,
    input  logic                pk_valid,
    input  logic [KEY_W-1:0]    pk_key,
    input  logic [REG_W-1:0]    lk_sel,
    input  logic [REG_W-1:0]    ins_sel,
    input  logic [REG_W-1:0]    pg_sel,
    input  logic [KEY_W-1:0]    key_in,
    output region_t             lk_rr,
    output region_t             ins_rr,
    output region_t             pg_rr,
    output logic                key_ok
);

    region_t            rr_q [N_REG];
    logic [N_PKR-1:0]   pk_v_q;
    logic [KEY_W-1:0]   pk_k_q [N_PKR];
    logic [N_PKR-1:0]   key_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REG; i++) rr_q[i] <= '0;
            for (int j = 0; j < N_PKR; j++) pk_k_q[j] <= '0;
            pk_v_q <= '0;
        end else begin
            if (rr_we) rr_q[rr_idx] <= rr_data;
            if (pk_we) begin
                pk_v_q[pk_idx] <= pk_valid;
                pk_k_q[pk_idx] <= pk_key;
            end
        end
    end

    assign lk_rr  = rr_q[lk_sel];
    assign ins_rr = rr_q[ins_sel];
    assign pg_rr  = rr_q[pg_sel];

    for (genvar k = 0; k < N_PKR; k++) begin : g_key
        assign key_hit[k] = pk_v_q[k] && (pk_k_q[k] == key_in);
    end
    assign key_ok = |key_hit;

    // R1
    rr_write_chk: assert property (@(posedge clk) disable iff (rst)
        rr_we |=> (rr_q[$past(rr_idx)] == $past(rr_data)));

    // R8
    key_write_chk: assert property (@(posedge clk) disable iff (rst)
        (pk_we && pk_valid) |=> (pk_v_q[$past(pk_idx)] && (pk_k_q[$past(pk_idx)] == $past(pk_key))));

endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int N = 8,
    parameter bit AUTO_REPL = 1'b0,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  tlb_entry_t        wr_entry,
    input  logic              purge_en,
    input  logic [RID_W-1:0]  purge_rid,
    input  logic [VPN_W-1:0]  purge_vpn,
    input  logic [PS_W-1:0]   purge_ps,
    input  logic [RID_W-1:0]  look_rid,
    input  logic [VPN_W-1:0]  look_vpn,
    output logic              hit,
    output logic              multi,
    output tlb_entry_t        hit_entry
);

    tlb_entry_t        slots [N];
    logic [N-1:0]      valid_vec;
    logic [N-1:0]      hit_vec;
    logic [N-1:0]      drop_vec;
    logic              any_free;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  ptr;
    logic [IDX_W-1:0]  tgt;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign valid_vec[i] = slots[i].valid;
        assign hit_vec[i]   = entry_matches(slots[i], look_rid, look_vpn);
        assign drop_vec[i]  = AUTO_REPL && purge_en &&
                              range_overlap(slots[i], purge_rid, purge_vpn, purge_ps);
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        int cnt;
        cnt       = 0;
        hit_entry = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                cnt       = cnt + 1;
                hit_entry = slots[i];
            end
        end
        hit   = (cnt != 0);
        multi = (cnt > 1);
    end

    assign tgt = AUTO_REPL ? (any_free ? free_idx : ptr) : wr_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) slots[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (drop_vec[i]) slots[i].valid <= 1'b0;
            end
            if (wr_en) slots[tgt] <= wr_entry;
        end
    end

    if (AUTO_REPL) begin : g_auto
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr <= '0;
            end else if (wr_en && !any_free) begin
                ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + IDX_W'(1);
            end
        end

        // R5
        fill_count_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !purge_en) |=>
                (($countones(valid_vec) == $countones($past(valid_vec)) + 1) || (&valid_vec)));

        // R11
        purge_shrink_chk: assert property (@(posedge clk) disable iff (rst)
            (purge_en && !wr_en) |=> ($countones(valid_vec) <= $countones($past(valid_vec))));
    end else begin : g_pinned
        assign ptr = '0;

        // R4
        pinned_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (|valid_vec) |=> (($past(valid_vec) & ~valid_vec) == '0));
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [AR_W-1:0] ar,
    input  logic [PL_W-1:0] pl,
    input  logic [PL_W-1:0] cpl,
    input  access_e         acc,
    output logic            fault
);

    logic [2:0] grant;
    logic       allowed;

    assign grant = rights_of(ar, cpl);

    always_comb begin
        case (acc)
            ACC_READ:  allowed = grant[0];
            ACC_WRITE: allowed = grant[1];
            ACC_EXEC:  allowed = grant[2];
            default:   allowed = 1'b0;
        endcase
    end

    assign fault = (cpl > pl) || !allowed;

endmodule

// File: rtl/tlb_split.sv
module tlb_split
    import tlb_pkg::*;
#(
    parameter int N_TR  = 4,
    parameter int N_TC  = 8,
    parameter int N_PKR = 16,
    localparam int TR_IDX_W = (N_TR > 1) ? $clog2(N_TR) : 1,
    localparam int TC_IDX_W = (N_TC > 1) ? $clog2(N_TC) : 1,
    localparam int PK_IDX_W = (N_PKR > 1) ? $clog2(N_PKR) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rr_we,
    input  logic [REG_W-1:0]       rr_idx,
    input  logic [RID_W-1:0]       rr_rid,
    input  logic [PS_W-1:0]        rr_ps,
    input  logic                   rr_walk,
    input  logic                   pk_we,
    input  logic [PK_IDX_W-1:0]    pk_idx,
    input  logic                   pk_valid,
    input  logic [KEY_W-1:0]       pk_key,
    input  logic                   ins_en,
    input  logic                   ins_tr,
    input  logic [TR_IDX_W-1:0]    ins_slot,
    input  logic [VA_W-1:PG_MIN]   ins_va,
    input  logic [PS_W-1:0]        ins_ps,
    input  logic [PPN_W-1:0]       ins_ppn,
    input  logic [AR_W-1:0]        ins_ar,
    input  logic [PL_W-1:0]        ins_pl,
    input  logic [KEY_W-1:0]       ins_key,
    input  logic                   purge_en,
    input  logic [VA_W-1:PG_MIN]   purge_va,
    input  logic [PS_W-1:0]        purge_ps,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_va,
    input  logic [1:0]             lk_acc,
    input  logic [PL_W-1:0]        lk_cpl,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic                   res_from_tr,
    output logic [PA_W-1:0]        res_pa,
    output logic                   res_acc_fault,
    output logic                   res_key_fault,
    output logic                   res_mchk,
    output logic                   res_walk_en
);

    localparam int VPN_LSB = PG_MIN;
    localparam int VPN_MSB = VA_W - REG_W - 1;

    region_t          lk_rr, ins_rr, pg_rr, rr_data;
    logic             key_ok;
    logic [PS_W-1:0]  ins_ps_eff;
    logic             ins_ok;
    tlb_entry_t       ins_entry;
    logic [VPN_W-1:0] lk_vpn;
    logic             tr_hit, tr_multi, tc_hit, tc_multi;
    tlb_entry_t       tr_e, tc_e, sel_e;
    logic             perm_fault;
    logic             any_hit;
    logic [PA_W-1:0]  pa_next;
    logic [PA_W-1:0]  low_mask;

    assign rr_data = '{rid: rr_rid, ps: rr_ps, walk: rr_walk};

    tlb_region_file #(.N_PKR(N_PKR)) u_regions (
        .clk      (clk),
        .rst      (rst),
        .rr_we    (rr_we),
        .rr_idx   (rr_idx),
        .rr_data  (rr_data),
        .pk_we    (pk_we),
        .pk_idx   (pk_idx),
        .pk_valid (pk_valid),
        .pk_key   (pk_key),
        .lk_sel   (lk_va[VA_W-1:VA_W-REG_W]),
        .ins_sel  (ins_va[VA_W-1:VA_W-REG_W]),
        .pg_sel   (purge_va[VA_W-1:VA_W-REG_W]),
        .key_in   (sel_e.key),
        .lk_rr    (lk_rr),
        .ins_rr   (ins_rr),
        .pg_rr    (pg_rr),
        .key_ok   (key_ok)
    );

    assign ins_ps_eff = (ins_ps == '0) ? ins_rr.ps : ins_ps;
    assign ins_ok     = ps_supported(ins_ps_eff);

    always_comb begin
        ins_entry       = '0;
        ins_entry.valid = 1'b1;
        ins_entry.rid   = ins_rr.rid;
        ins_entry.vpn   = ins_va[VPN_MSB:VPN_LSB] & vpn_mask(ins_ps_eff);
        ins_entry.ps    = ins_ps_eff;
        ins_entry.ppn   = ins_ppn;
        ins_entry.ar    = ins_ar;
        ins_entry.pl    = ins_pl;
        ins_entry.key   = ins_key;
    end

    assign lk_vpn = lk_va[VPN_MSB:VPN_LSB];

    tlb_array #(.N(N_TR), .AUTO_REPL(1'b0)) u_pinned (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ins_en && ins_tr && ins_ok),
        .wr_slot   (ins_slot),
        .wr_entry  (ins_entry),
        .purge_en  (1'b0),
        .purge_rid (pg_rr.rid),
        .purge_vpn (purge_va[VPN_MSB:VPN_LSB]),
        .purge_ps  (purge_ps),
        .look_rid  (lk_rr.rid),
        .look_vpn  (lk_vpn),
        .hit       (tr_hit),
        .multi     (tr_multi),
        .hit_entry (tr_e)
    );

    tlb_array #(.N(N_TC), .AUTO_REPL(1'b1)) u_cache (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ins_en && !ins_tr && ins_ok),
        .wr_slot   (TC_IDX_W'(0)),
        .wr_entry  (ins_entry),
        .purge_en  (purge_en),
        .purge_rid (pg_rr.rid),
        .purge_vpn (purge_va[VPN_MSB:VPN_LSB]),
        .purge_ps  (purge_ps),
        .look_rid  (lk_rr.rid),
        .look_vpn  (lk_vpn),
        .hit       (tc_hit),
        .multi     (tc_multi),
        .hit_entry (tc_e)
    );

    assign any_hit = tr_hit || tc_hit;
    assign sel_e   = tr_hit ? tr_e : tc_e;

    tlb_perm u_perm (
        .ar    (sel_e.ar),
        .pl    (sel_e.pl),
        .cpl   (lk_cpl),
        .acc   (access_e'(lk_acc)),
        .fault (perm_fault)
    );

    assign low_mask = offset_mask(sel_e.ps);
    assign pa_next  = ({sel_e.ppn, {PG_MIN{1'b0}}} & ~low_mask) | (lk_va[PA_W-1:0] & low_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_hit       <= 1'b0;
            res_from_tr   <= 1'b0;
            res_pa        <= '0;
            res_acc_fault <= 1'b0;
            res_key_fault <= 1'b0;
            res_mchk      <= 1'b0;
            res_walk_en   <= 1'b0;
        end else begin
            res_valid     <= lk_valid;
            res_hit       <= lk_valid && any_hit;
            res_from_tr   <= lk_valid && tr_hit;
            res_pa        <= (lk_valid && any_hit) ? pa_next : '0;
            res_acc_fault <= lk_valid && any_hit && perm_fault;
            res_key_fault <= lk_valid && any_hit && !key_ok;
            res_mchk      <= lk_valid && (tr_multi || tc_multi);
            res_walk_en   <= lk_valid && !any_hit && lk_rr.walk;
        end
    end

    // R12
    res_timing_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R12
    res_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    // R6
    from_tr_chk: assert property (@(posedge clk) disable iff (rst)
        res_from_tr |-> (res_hit && res_valid));

    // R10
    miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> ((res_pa == '0) && !res_acc_fault && !res_key_fault));

    // R7
    mchk_hit_chk: assert property (@(posedge clk) disable iff (rst)
        res_mchk |-> res_hit);

endmodule

// File: tb/test_tlb_split.sv
module test_tlb_split;
    import tlb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              rr_we = 0;
    logic [2:0]        rr_idx = 0;
    logic [7:0]        rr_rid = 0;
    logic [5:0]        rr_ps = 0;
    logic              rr_walk = 0;
    logic              pk_we = 0;
    logic [3:0]        pk_idx = 0;
    logic              pk_valid = 0;
    logic [7:0]        pk_key = 0;
    logic              ins_en = 0;
    logic              ins_tr = 0;
    logic [1:0]        ins_slot = 0;
    logic [63:12]      ins_va = 0;
    logic [5:0]        ins_ps = 0;
    logic [37:0]       ins_ppn = 0;
    logic [2:0]        ins_ar = 0;
    logic [1:0]        ins_pl = 0;
    logic [7:0]        ins_key = 0;
    logic              purge_en = 0;
    logic [63:12]      purge_va = 0;
    logic [5:0]        purge_ps = 0;
    logic              lk_valid = 0;
    logic [63:0]       lk_va = 0;
    logic [1:0]        lk_acc = 0;
    logic [1:0]        lk_cpl = 0;
    logic              res_valid, res_hit, res_from_tr, res_acc_fault;
    logic              res_key_fault, res_mchk, res_walk_en;
    logic [49:0]       res_pa;

    tlb_split i_tlb_split (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic set_rr(input int idx, input logic [7:0] rid, input logic [5:0] ps, input logic w);
        @(negedge clk);
        rr_we = 1; rr_idx = 3'(idx); rr_rid = rid; rr_ps = ps; rr_walk = w;
        @(negedge clk); rr_we = 0;
    endtask

    task automatic set_pk(input int idx, input logic v, input logic [7:0] key);
        @(negedge clk);
        pk_we = 1; pk_idx = 4'(idx); pk_valid = v; pk_key = key;
        @(negedge clk); pk_we = 0;
    endtask

    task automatic insert(input logic tr, input int slot, input logic [63:0] va, input logic [5:0] ps,
                          input logic [37:0] ppn, input logic [2:0] ar, input logic [1:0] pl,
                          input logic [7:0] key);
        @(negedge clk);
        ins_en = 1; ins_tr = tr; ins_slot = 2'(slot); ins_va = va[63:12]; ins_ps = ps;
        ins_ppn = ppn; ins_ar = ar; ins_pl = pl; ins_key = key;
        @(negedge clk); ins_en = 0;
    endtask

    task automatic purge(input logic [63:0] va, input logic [5:0] ps);
        @(negedge clk);
        purge_en = 1; purge_va = va[63:12]; purge_ps = ps;
        @(negedge clk); purge_en = 0;
    endtask

    task automatic lookup(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] cpl);
        @(negedge clk);
        lk_valid = 1; lk_va = va; lk_acc = acc; lk_cpl = cpl;
        @(negedge clk); lk_valid = 0;
    endtask

    function automatic logic [63:0] exp_pa(input logic [63:0] va, input logic [37:0] ppn, input int ps);
        logic [63:0] base;
        base = {26'h0, ppn} << 12;
        base = (base >> ps) << ps;
        return (base | (va & ((64'd1 << ps) - 64'd1))) & ((64'd1 << 50) - 64'd1);
    endfunction

    function automatic logic exp_fault(input int ar, input int cpl, input int pl, input int acc);
        logic r, w, x, ok;
        r = (ar <= 5);
        w = (ar == 2) || (ar == 3) || (((ar == 4) || (ar == 5)) && (cpl == 0));
        x = (ar == 1) || (ar == 3) || (ar == 5);
        ok = (acc == 0) ? r : (acc == 1) ? w : (acc == 2) ? x : 1'b0;
        return (cpl > pl) || !ok;
    endfunction

    task automatic init_regions();
        for (int r = 0; r < 8; r++) set_rr(r, 8'(8'h20 + r), (r == 0) ? 6'd14 : 6'd16, r[0]);
        set_pk(0, 1'b1, 8'd5);
    endtask

    function automatic logic [63:0] pg4(input int n);
        return {3'd4, 61'h0} | (64'(n) << 12);
    endfunction

    initial begin
        int sizes [11] = '{12, 13, 14, 16, 18, 20, 22, 24, 26, 28, 32};
        logic [63:0] va;
        logic [37:0] ppn;

        do_reset();
        chk("R12 reset valid", res_valid, 0);
        lookup(64'h0, 2'd0, 2'd0);
        chk("R12 result valid next cycle", res_valid, 1);
        chk("R12 reset miss", res_hit, 0);
        chk("R12 reset walk", res_walk_en, 0);
        @(negedge clk);
        chk("R12 idle valid low", res_valid, 0);

        init_regions();
        for (int r = 0; r < 8; r++) begin
            lookup({3'(r), 61'h1234567}, 2'd0, 2'd0);
            chk("R10 miss hit", res_hit, 0);
            chk("R10 miss walk", res_walk_en, 64'(r % 2));
            chk("R10 miss pa", res_pa, 0);
        end

        // R2 R3: page size sweep in the pinned array
        for (int s = 0; s < 11; s++) begin
            int ps = sizes[s];
            va  = {3'd1, 61'h0A5A_5A5A_5A5A_5A5A};
            ppn = 38'h2A_BCDE_F012;
            insert(1'b1, 0, va, 6'(ps), ppn, 3'd3, 2'd3, 8'd5);
            lookup(va, 2'd0, 2'd0);
            chk("R3 hit", res_hit, 1);
            chk("R3 pa", res_pa, exp_pa(va, ppn, ps));
            chk("R10 hit walk low", res_walk_en, 0);
            lookup(va ^ ((64'd1 << ps) - 64'd1), 2'd0, 2'd0);
            chk("R3 offset pass pa", res_pa, exp_pa(va ^ ((64'd1 << ps) - 64'd1), ppn, ps));
            lookup(va ^ (64'd1 << ps), 2'd0, 2'd0);
            chk("R3 page bit miss", res_hit, 0);
        end
        insert(1'b1, 1, {3'd3, 61'h7000}, 6'd15, 38'h1, 3'd3, 2'd3, 8'd5);
        lookup({3'd3, 61'h7000}, 2'd0, 2'd0);
        chk("R2 bad size dropped", res_hit, 0);
        insert(1'b1, 2, {3'd0, 61'h40000}, 6'd0, 38'h9, 3'd3, 2'd3, 8'd5);
        lookup({3'd0, 61'h40000} ^ (64'd1 << 13), 2'd0, 2'd0);
        chk("R2 preferred size inside", res_hit, 1);
        lookup({3'd0, 61'h40000} ^ (64'd1 << 14), 2'd0, 2'd0);
        chk("R2 preferred size outside", res_hit, 0);

        // R1: region identifier match
        va = {3'd1, 61'h55000};
        insert(1'b1, 0, va, 6'd12, 38'h33, 3'd3, 2'd3, 8'd5);
        lookup({3'd2, 61'h55000}, 2'd0, 2'd0);
        chk("R1 other region miss", res_hit, 0);
        set_rr(2, 8'h21, 6'd16, 1'b0);
        lookup({3'd2, 61'h55000}, 2'd0, 2'd0);
        chk("R1 shared rid hit", res_hit, 1);
        chk("R1 shared rid pa", res_pa, exp_pa({3'd2, 61'h55000}, 38'h33, 12));
        set_rr(2, 8'h22, 6'd16, 1'b0);

        // R9: rights x privilege x access sweep (entry privilege level 1)
        va = {3'd1, 61'h99000};
        for (int ar = 0; ar < 8; ar++) begin
            insert(1'b1, 0, va, 6'd12, 38'h44, 3'(ar), 2'd1, 8'd5);
            for (int cpl = 0; cpl < 4; cpl++)
                for (int acc = 0; acc < 4; acc++) begin
                    lookup(va, 2'(acc), 2'(cpl));
                    chk("R9 access fault", res_acc_fault, 64'(exp_fault(ar, cpl, 1, acc)));
                end
        end

        // R8: protection keys
        chk("R8 matching key", res_key_fault, 0);
        insert(1'b1, 0, va, 6'd12, 38'h44, 3'd3, 2'd3, 8'd6);
        lookup(va, 2'd0, 2'd0);
        chk("R8 key miss", res_key_fault, 1);
        set_pk(15, 1'b1, 8'd6);
        lookup(va, 2'd0, 2'd0);
        chk("R8 key added", res_key_fault, 0);
        set_pk(15, 1'b0, 8'd6);
        lookup(va, 2'd0, 2'd0);
        chk("R8 key invalidated", res_key_fault, 1);

        // R5: cache fill and rotation
        do_reset();
        init_regions();
        for (int n = 0; n < 8; n++) insert(1'b0, 0, pg4(n), 6'd12, 38'(12'h100 + n), 3'd3, 2'd3, 8'd5);
        for (int n = 0; n < 8; n++) begin
            lookup(pg4(n), 2'd0, 2'd0);
            chk("R5 fill hit", res_hit, 1);
            chk("R5 fill pa", res_pa, exp_pa(pg4(n), 38'(12'h100 + n), 12));
        end
        insert(1'b0, 0, pg4(8), 6'd12, 38'h108, 3'd3, 2'd3, 8'd5);
        lookup(pg4(0), 2'd0, 2'd0);
        chk("R5 slot0 replaced", res_hit, 0);
        lookup(pg4(8), 2'd0, 2'd0);
        chk("R5 new entry hit", res_hit, 1);
        insert(1'b0, 0, pg4(9), 6'd12, 38'h109, 3'd3, 2'd3, 8'd5);
        lookup(pg4(1), 2'd0, 2'd0);
        chk("R5 slot1 replaced", res_hit, 0);
        lookup(pg4(2), 2'd0, 2'd0);
        chk("R5 slot2 kept", res_hit, 1);

        // R6: pinned wins
        insert(1'b1, 0, pg4(2), 6'd12, 38'h777, 3'd3, 2'd3, 8'd5);
        lookup(pg4(2), 2'd0, 2'd0);
        chk("R6 pinned source", res_from_tr, 1);
        chk("R6 pinned pa", res_pa, exp_pa(pg4(2), 38'h777, 12));
        lookup(pg4(3), 2'd0, 2'd0);
        chk("R6 cache source", res_from_tr, 0);
        chk("R7 single hit", res_mchk, 0);

        // R7: duplicates
        insert(1'b1, 1, pg4(2), 6'd12, 38'h778, 3'd3, 2'd3, 8'd5);
        lookup(pg4(2), 2'd0, 2'd0);
        chk("R7 pinned multi", res_mchk, 1);
        chk("R7 lowest slot pa", res_pa, exp_pa(pg4(2), 38'h777, 12));
        insert(1'b0, 0, pg4(4), 6'd12, 38'h204, 3'd3, 2'd3, 8'd5);
        lookup(pg4(4), 2'd0, 2'd0);
        chk("R7 cache multi", res_mchk, 1);

        // R11 / R4: purge
        purge(pg4(4), 6'd12);
        lookup(pg4(4), 2'd0, 2'd0);
        chk("R11 purged page", res_hit, 0);
        lookup(pg4(5), 2'd0, 2'd0);
        chk("R11 neighbour kept", res_hit, 1);
        purge({3'd5, 61'h0}, 6'd32);
        lookup(pg4(5), 2'd0, 2'd0);
        chk("R11 other region kept", res_hit, 1);
        purge(pg4(7), 6'd16);
        lookup(pg4(5), 2'd0, 2'd0);
        chk("R11 range purge", res_hit, 0);
        lookup(pg4(9), 2'd0, 2'd0);
        chk("R11 range purge high", res_hit, 0);
        lookup(pg4(2), 2'd0, 2'd0);
        chk("R4 pinned survives", res_from_tr, 1);
        chk("R4 pinned pa", res_pa, exp_pa(pg4(2), 38'h777, 12));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule